// File: doc/BRIEF.md
# Supply and Activity Reset Supervisor

This block produces the system reset for a processor. Two conditions raise it. The first is a supply-good flag, which comes already digitised from an external comparator. The second is a watchdog that watches a chip-select line. A low supply forces reset at once. When the supply returns, reset stays asserted for a fixed hold time, counted in clock cycles. The same hold follows power-up and every watchdog expiry.

The watchdog counts clock cycles from the moment reset releases. The only thing that restarts the count is a falling edge on chip select. A line that stays high, or stays low, longer than the selected period is treated as a hung processor. A 2-bit select code picks one of three periods or turns the watchdog off, and a separate enable input can also turn it off.

Reset is driven in both polarities. A status flag records that the last reset came from the watchdog and keeps that record until the supply next drops. The pins are all plain control signals: there is no data stream and no handshake. Open-drain behaviour is left to the pad ring. The outputs here are push-pull logic levels.

Top module: `sup_reset_ctrl`

## Requirements
- R1: While `arst_n` is low, `rst_o` is 1, `rst_n_o` is 0 and `wd_flag` is 0.
- R2: At a rising clock edge that samples `supply_ok` low, the edge sets `rst_o` to 1 and clears `wd_flag`. Reset then stays asserted as long as `supply_ok` is low.
- R3: After power-up or a supply drop, `rst_o` stays 1 through the first HOLD_CYC-1 rising edges that sample `supply_ok` high. It falls at the HOLD_CYC-th such edge.
- R4: The watchdog runs only while reset is released. Suppose `wd_en` is 1, `wd_tsel` is not 3 and `cs_n` has no falling edge. Then `rst_o` rises at exactly the LIMIT-th rising edge after the edge that released reset. This holds whether `cs_n` sits high or low.
- R5: The `wd_tsel` codes select the period: 0 gives WD_LONG, 1 gives WD_MED, 2 gives WD_SHORT, and 3 disables the watchdog.
- R6: A falling edge on `cs_n` restarts the count. The restart takes effect at the third rising edge after the pin falls: two synchroniser flops plus one edge-detect register. Expiry then comes LIMIT edges after the restart. Falling edges that arrive more often than every LIMIT cycles keep reset released.
- R7: A rising edge on `cs_n`, or a steady level, does not restart the count.
- R8: With `wd_en` at 0, reset depends on the supply alone.
- R9: A watchdog expiry holds `rst_o` at 1 for exactly HOLD_CYC cycles. The count then restarts from zero at release.
- R10: `rst_n_o` is always the complement of `rst_o`.
- R11: A watchdog expiry sets `wd_flag`. The flag stays set until an edge samples `supply_ok` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; all delays are counted in its cycles |
| arst_n | input | 1 | Asynchronous power-on clear, active low |
| supply_ok | input | 1 | Digital supply-good flag from the comparator (1 = above threshold) |
| cs_n | input | 1 | Chip-select line being watched, asynchronous |
| wd_en | input | 1 | Watchdog enable |
| wd_tsel | input | 2 | Timeout select: 0 long, 1 medium, 2 short, 3 off |
| rst_o | output | 1 | System reset, active high |
| rst_n_o | output | 1 | System reset, active low |
| wd_flag | output | 1 | Set when the watchdog caused the current or last reset |

## Verification
A wrong hold count shows up as an early or late fall of `rst_o`. The bench sees it at the first release after power-up, HOLD_CYC cycles in. A wrong watchdog state shows up as a reassertion that comes one or more cycles away from LIMIT after release. A restart that responds to the wrong edge, or to no edge, moves expiry by the full offset between the edge and the release. A stuck or uncleared status flag is visible on `wd_flag` one cycle after the expiry or after the supply drop that should have changed it.

// File: rtl/sup_pkg.sv
package sup_pkg;

  typedef enum logic [1:0] {
    TSEL_LONG  = 2'd0,
    TSEL_MED   = 2'd1,
    TSEL_SHORT = 2'd2,
    TSEL_OFF   = 2'd3
  } tsel_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/sup_cs_sync.sv
module sup_cs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic cs_n_i,
  output logic fall_o
);

  logic [STAGES-1:0] chain_q;
  logic              last_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge arst_n) begin
          if (!arst_n) chain_q[0] <= 1'b1;
          else         chain_q[0] <= cs_n_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge arst_n) begin
          if (!arst_n) chain_q[i] <= 1'b1;
          else         chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) last_q <= 1'b1;
    else         last_q <= chain_q[STAGES-1];
  end

  assign fall_o = last_q & ~chain_q[STAGES-1];

  AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!arst_n)
    fall_o |=> !fall_o); // R6

endmodule

// File: rtl/sup_wdog.sv
module sup_wdog
  import sup_pkg::*;
#(
  parameter int WD_LONG  = 1000,
  parameter int WD_MED   = 500,
  parameter int WD_SHORT = 100,
  localparam int CW      = $clog2(max3(WD_LONG, WD_MED, WD_SHORT) + 1)
) (
  input  logic  clk,
  input  logic  arst_n,
  input  logic  run_i,
  input  tsel_e tsel_i,
  input  logic  kick_i,
  output logic  bite_o
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] limit;
  logic          armed;

  always_comb begin
    unique case (tsel_i)
      TSEL_LONG:  limit = CW'(WD_LONG);
      TSEL_MED:   limit = CW'(WD_MED);
      TSEL_SHORT: limit = CW'(WD_SHORT);
      default:    limit = CW'(WD_LONG);
    endcase
  end

  assign armed  = run_i && (tsel_i != TSEL_OFF);
  assign bite_o = armed && !kick_i && (cnt_q == limit - CW'(1));

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)                        cnt_q <= '0;
    else if (!armed || kick_i || bite_o) cnt_q <= '0;
    else                                cnt_q <= cnt_q + CW'(1);
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!arst_n)
    armed |-> (cnt_q < limit)); // R4

  AST_IDLE_NO_BITE: assert property (@(posedge clk) disable iff (!arst_n)
    $past(!armed) |-> !bite_o || (limit == CW'(1))); // R8

endmodule

// File: rtl/sup_hold.sv
module sup_hold #(
  parameter int  HOLD_CYC = 25_000_000,
  localparam int HW       = $clog2(HOLD_CYC + 1)
) (
  input  logic clk,
  input  logic arst_n,
  input  logic supply_ok_i,
  input  logic bite_i,
  output logic rst_o
);

  logic [HW-1:0] hold_q;
  logic          rst_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      hold_q <= HW'(HOLD_CYC - 1);
      rst_q  <= 1'b1;
    end else if (!supply_ok_i || bite_i) begin
      hold_q <= HW'(HOLD_CYC - 1);
      rst_q  <= 1'b1;
    end else if (hold_q != '0) begin
      hold_q <= hold_q - HW'(1);
      rst_q  <= 1'b1;
    end else begin
      rst_q  <= 1'b0;
    end
  end

  assign rst_o = rst_q;

  AST_SUPPLY_LOW_RST: assert property (@(posedge clk) disable iff (!arst_n)
    !supply_ok_i |=> rst_q); // R2

  AST_RELEASE_NEEDS_SUPPLY: assert property (@(posedge clk) disable iff (!arst_n)
    $fell(rst_q) |-> $past(supply_ok_i)); // R3

  AST_BITE_HOLDS: assert property (@(posedge clk) disable iff (!arst_n)
    bite_i |=> rst_q); // R9

endmodule

// File: rtl/sup_reset_ctrl.sv
module sup_reset_ctrl
  import sup_pkg::*;
#(
  parameter int HOLD_CYC = 25_000_000,
  parameter int WD_LONG  = 175_000_000,
  parameter int WD_MED   = 75_000_000,
  parameter int WD_SHORT = 18_750_000,
  parameter int SYNC_STG = 2
) (
  input  logic       clk,
  input  logic       arst_n,
  input  logic       supply_ok,
  input  logic       cs_n,
  input  logic       wd_en,
  input  logic [1:0] wd_tsel,
  output logic       rst_o,
  output logic       rst_n_o,
  output logic       wd_flag
);

  logic  cs_fall;
  logic  bite;
  logic  rst_int;
  logic  wd_run;
  logic  flag_q;
  tsel_e tsel;

  assign tsel   = tsel_e'(wd_tsel);
  assign wd_run = wd_en && supply_ok && !rst_int;

  sup_cs_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk    (clk),
    .arst_n (arst_n),
    .cs_n_i (cs_n),
    .fall_o (cs_fall)
  );

  sup_wdog #(
    .WD_LONG  (WD_LONG),
    .WD_MED   (WD_MED),
    .WD_SHORT (WD_SHORT)
  ) u_wdog (
    .clk    (clk),
    .arst_n (arst_n),
    .run_i  (wd_run),
    .tsel_i (tsel),
    .kick_i (cs_fall),
    .bite_o (bite)
  );

  sup_hold #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk         (clk),
    .arst_n      (arst_n),
    .supply_ok_i (supply_ok),
    .bite_i      (bite),
    .rst_o       (rst_int)
  );

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)         flag_q <= 1'b0;
    else if (!supply_ok) flag_q <= 1'b0;
    else if (bite)       flag_q <= 1'b1;
  end

  assign rst_o   = rst_int;
  assign rst_n_o = ~rst_int;
  assign wd_flag = flag_q;

  AST_FLAG_ON_BITE: assert property (@(posedge clk) disable iff (!arst_n)
    bite |=> (wd_flag && rst_o)); // R11

  AST_FLAG_CLR: assert property (@(posedge clk) disable iff (!arst_n)
    !supply_ok |=> !wd_flag); // R11

  AST_NO_BITE_IN_RESET: assert property (@(posedge clk) disable iff (!arst_n)
    rst_o |-> !bite); // R4

endmodule

// File: tb/sup_reset_ctrl_tb.sv
module sup_reset_ctrl_tb;

  localparam int HOLD  = 12;
  localparam int LLONG = 40;
  localparam int LMED  = 24;
  localparam int LSHRT = 10;
  localparam int CAP   = 120;
  localparam int NVEC  = 6;

  // columns: tsel, enable, cs level, expected expiry cycle (0 = none)
  localparam logic [1:0] V_SEL [NVEC] = '{2'd0, 2'd1, 2'd2, 2'd2, 2'd3, 2'd0};
  localparam logic       V_EN  [NVEC] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0};
  localparam logic       V_CS  [NVEC] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0};
  localparam int         V_EXP [NVEC] = '{LLONG, LMED, LSHRT, LSHRT, 0, 0};

  logic       clk = 1'b0;
  logic       arst_n = 1'b0;
  logic       supply_ok = 1'b1;
  logic       cs_n = 1'b1;
  logic       wd_en = 1'b0;
  logic [1:0] wd_tsel = 2'd3;
  logic       rst_o, rst_n_o, wd_flag;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sup_reset_ctrl #(
    .HOLD_CYC (HOLD),
    .WD_LONG  (LLONG),
    .WD_MED   (LMED),
    .WD_SHORT (LSHRT)
  ) u_dut (
    .clk       (clk),
    .arst_n    (arst_n),
    .supply_ok (supply_ok),
    .cs_n      (cs_n),
    .wd_en     (wd_en),
    .wd_tsel   (wd_tsel),
    .rst_o     (rst_o),
    .rst_n_o   (rst_n_o),
    .wd_flag   (wd_flag)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_release(output int m);
    m = 0;
    do begin
      @(posedge clk); @(negedge clk);
      m++;
    end while (rst_o && m < CAP);
  endtask

  task automatic meas_bite(input int fall_at, input int rise_at, output int n);
    n = 0;
    for (int k = 1; k <= CAP; k++) begin
      @(posedge clk); @(negedge clk);
      if (rst_o) begin n = k; break; end
      if (k == fall_at) cs_n = 1'b0;
      if (k == rise_at) cs_n = 1'b1;
    end
  endtask

  task automatic supply_drop();
    supply_ok = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R2 rst_o after supply low", rst_o, 1);
    check("R2 wd_flag cleared", wd_flag, 0);
  endtask

  initial begin
    int m, n;
    @(negedge clk); @(negedge clk);
    check("R1 rst_o in reset", rst_o, 1);
    check("R1 rst_n_o in reset", rst_n_o, 0);
    check("R1 wd_flag in reset", wd_flag, 0);
    arst_n = 1'b1;
    wait_release(m);
    check("R3 power-up hold", m, HOLD);

    for (int i = 0; i < NVEC; i++) begin
      supply_drop();
      wd_tsel = V_SEL[i]; wd_en = V_EN[i]; cs_n = V_CS[i];
      @(negedge clk);
      supply_ok = 1'b1;
      wait_release(m);
      check("R3 hold after supply return", m, HOLD);
      meas_bite(-1, -1, n);
      if (V_EN[i]) check("R4 R5 expiry cycle", n, V_EXP[i]);
      else         check("R8 disabled watchdog", n, V_EXP[i]);
      if (n != 0) begin
        check("R11 flag after expiry", wd_flag, 1);
        check("R10 complement", rst_n_o, 0);
        wait_release(m);
        check("R9 hold after expiry", m, HOLD);
        check("R11 flag kept after release", wd_flag, 1);
        meas_bite(-1, -1, n);
        check("R9 count restarts at release", n, V_EXP[i]);
      end else begin
        check("R10 complement released", rst_n_o, 1);
      end
    end

    // R6 exact restart: pin falls after sample 5
    supply_drop();
    wd_tsel = 2'd2; wd_en = 1'b1; cs_n = 1'b1;
    @(negedge clk); supply_ok = 1'b1;
    wait_release(m);
    meas_bite(5, -1, n);
    check("R6 restart by falling edge", n, 5 + 3 + LSHRT);

    // R7 rising edge does not restart
    supply_drop();
    cs_n = 1'b0;
    @(negedge clk); supply_ok = 1'b1;
    wait_release(m);
    meas_bite(-1, 4, n);
    check("R7 rising edge ignored", n, LSHRT);

    // R6 periodic falling edges keep reset released
    supply_drop();
    cs_n = 1'b1;
    @(negedge clk); supply_ok = 1'b1;
    wait_release(m);
    n = 0;
    for (int k = 1; k <= 100; k++) begin
      @(posedge clk); @(negedge clk);
      if (rst_o) n++;
      if (k % 4 == 0) cs_n = ~cs_n;
    end
    check("R6 periodic service no reset", n, 0);

    // R11 flag cleared by supply drop after an expiry
    cs_n = 1'b1;
    meas_bite(-1, -1, n);
    check("R11 expiry with idle line", n != 0, 1);
    check("R11 flag set", wd_flag, 1);
    supply_drop();

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule